// File: doc/BRIEF.md
# Reset Sequencer with Cause Register

This block sequences the system reset of a small microcontroller. A comparator outside the block reports whether the supply is good. Three further requests can also start a reset: an external pin, a watchdog timeout and a software request. The block drives one active-high system reset. While the reset is held, the processor stays stopped. When the reset is released, the processor always starts at one fixed address.

A supply that becomes good starts the long power-on hold. This hold is a cycle count, and an input selects one of two lengths (the low-voltage or the high-voltage setting). Pin, watchdog and software requests give a short warm hold. A cause register records what started the last reset. A monitor-disable bit lives in a small power-mode register. Setting it makes the block ignore supply-good drops. While the bit is set, any request starts a full power-on sequence instead of a warm reset, and that sequence clears the bit.

The block has four states:
- `ST_POR_HOLD`: waits for the synchronised supply-good signal.
- `ST_POR_CNT`: counts the power-on delay.
- `ST_WARM`: counts the warm delay.
- `ST_RUN`: the reset is released.

The transitions are:
- HOLD→CNT when the supply is good.
- CNT→HOLD and WARM→HOLD when the supply drops.
- CNT→RUN and WARM→RUN when the count expires.
- RUN→HOLD on a monitored supply drop, or on any request while the monitor is disabled.
- RUN→WARM on a request while the monitor is enabled.

Top module: `rstseq_top`

## Requirements
- R1: While `cold_n` is low, and afterwards until a power-on sequence completes, `sys_rst` is 1. Directly after `cold_n` rises, `rst_src` and `mode_reg` read 0.
- R2: `supply_ok`, `pin_req` and `wdog_req` each pass through a two-flop synchroniser. After the first clock edge that samples `supply_ok` high, `sys_rst` falls at edge number N+3, where N is `POR_LONG_CYC` when `dly_sel` is 1 and `POR_SHORT_CYC` otherwise.
- R3: When a power-on sequence completes, bit 1 of `rst_src` reads 1. The other bits of `rst_src` carry no meaning while bit 1 is set.
- R4: A pin, watchdog or software request seen while the reset is released holds `sys_rst` high for exactly `WARM_CYC` cycles. `sw_req` is synchronous and takes effect at the first edge that samples it.
- R5: A warm reset clears bit 1 of `rst_src` and sets exactly one cause bit: bit 0 for the pin, bit 2 for the watchdog, bit 3 for software. When requests coincide, the pin wins over the watchdog, and the watchdog wins over software.
- R6: While the monitor is enabled, a synchronised supply-good low in any state asserts `sys_rst` at the next edge. It also restarts the power-on delay from zero once the supply is good again.
- R7: A write with bit 5 of `mode_wdata` set, made while the reset is released, sets bit 5 of `mode_reg` (monitor disabled). While that bit is set, supply-good drops leave `sys_rst` low.
- R8: While the monitor is disabled, any request starts a full power-on sequence with the power-on delay and bit 1 of `rst_src` set. The sequence clears bit 5 of `mode_reg`.
- R9: Pin, watchdog and software requests that arrive while `sys_rst` is high are ignored. `rst_src` keeps its value and the hold length does not change.
- R10: Writes to `mode_reg` while `sys_rst` is high are ignored. Every bit of `mode_reg` other than bit 5 always reads 0.
- R11: `start_addr` equals `BOOT_VEC` (0 by default) whenever the reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| cold_n | input | 1 | Power-present clear, low only when power is first applied |
| supply_ok | input | 1 | Asynchronous supply-good indication from the comparator |
| dly_sel | input | 1 | Power-on delay select: 1 for the long count, 0 for the short count |
| pin_req | input | 1 | Asynchronous external pin reset request |
| wdog_req | input | 1 | Asynchronous watchdog reset request |
| sw_req | input | 1 | Synchronous software reset request |
| mode_wr | input | 1 | Write strobe for the power-mode register |
| mode_wdata | input | 8 | Write data for the power-mode register; bit 5 is monitor disable |
| sys_rst | output | 1 | Active-high system reset |
| rst_src | output | 8 | Reset cause register |
| mode_reg | output | 8 | Power-mode register readback |
| start_addr | output | ADDR_W | Execution start address after reset |

## Verification
A supply-good change reaches the state machine three edges after it is first sampled: two synchroniser edges, then the state edge. The power-on release therefore comes N edges after that. A pin or watchdog request turns into a reset two edges later than a software request, because it passes through the synchroniser first. A warm hold lasts exactly `WARM_CYC` cycles. The bench keeps a behavioural model with the same synchroniser depth and countdown. It advances that model at each rising edge, and it compares `sys_rst`, `rst_src`, `mode_reg` and `start_addr` at the following falling edge. This puts every comparison on the cycle in which the result becomes due. While the power-on flag is set, only that flag is compared.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        ST_POR_HOLD = 2'd0,
        ST_POR_CNT  = 2'd1,
        ST_WARM     = 2'd2,
        ST_RUN      = 2'd3
    } rs_state_t;

    localparam int FLG_PIN   = 0;
    localparam int FLG_POR   = 1;
    localparam int FLG_WDOG  = 2;
    localparam int FLG_SW    = 3;
    localparam int MODE_MDIS = 5;
    localparam int REG_W     = 8;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          hold,
    input  logic [CW-1:0] lim,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            cnt_q <= '0;
        end else if (hold) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == lim - 1'b1);
endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
    import rstseq_pkg::*;
(
    input  logic             clk,
    input  logic             clr_n,
    input  logic             set_por,
    input  logic             set_warm,
    input  logic [REG_W-1:0] cause,
    input  logic             mode_we,
    input  logic             mode_din,
    input  logic             clr_mdis,
    output logic [REG_W-1:0] src_q,
    output logic             mdis_q
);
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            src_q <= '0;
        end else if (set_por) begin
            src_q          <= '0;
            src_q[FLG_POR] <= 1'b1;
        end else if (set_warm) begin
            src_q <= cause;
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            mdis_q <= 1'b0;
        end else if (clr_mdis) begin
            mdis_q <= 1'b0;
        end else if (mode_we) begin
            mdis_q <= mode_din;
        end
    end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int                POR_SHORT_CYC = 700000,
    parameter int                POR_LONG_CYC  = 1500000,
    parameter int                WARM_CYC      = 16,
    parameter int                ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] BOOT_VEC      = '0
) (
    input  logic              clk,
    input  logic              cold_n,
    input  logic              supply_ok,
    input  logic              dly_sel,
    input  logic              pin_req,
    input  logic              wdog_req,
    input  logic              sw_req,
    input  logic              mode_wr,
    input  logic [7:0]        mode_wdata,
    output logic              sys_rst,
    output logic [7:0]        rst_src,
    output logic [7:0]        mode_reg,
    output logic [ADDR_W-1:0] start_addr
);
    localparam int MAX_A = (POR_SHORT_CYC > POR_LONG_CYC) ? POR_SHORT_CYC : POR_LONG_CYC;
    localparam int MAX_C = (MAX_A > WARM_CYC) ? MAX_A : WARM_CYC;
    localparam int CW    = $clog2(MAX_C + 1);

    rs_state_t  st_q, st_d;
    logic [2:0] raw_in, syn_out;
    logic       sup_s, pin_s, wdog_s, any_req;
    logic       sel_q, tmr_done, tmr_hold;
    logic [CW-1:0] tmr_lim;
    logic [REG_W-1:0] cause, src_q;
    logic       mdis_q, set_por, set_warm, mode_we, clr_mdis;

    // synchronisers for the asynchronous inputs
    assign raw_in = {wdog_req, pin_req, supply_ok};

    rstseq_sync #(.W(3)) u_sync (
        .clk   (clk),
        .clr_n (cold_n),
        .d     (raw_in),
        .q     (syn_out)
    );

    assign sup_s   = syn_out[0];
    assign pin_s   = syn_out[1];
    assign wdog_s  = syn_out[2];
    assign any_req = pin_s | wdog_s | sw_req;

    // delay selection, captured while waiting for supply
    always_ff @(posedge clk or negedge cold_n) begin
        if (!cold_n) begin
            sel_q <= 1'b0;
        end else if (st_q == ST_POR_HOLD) begin
            sel_q <= dly_sel;
        end
    end

    assign tmr_hold = (st_q == ST_POR_HOLD) || (st_q == ST_RUN);
    assign tmr_lim  = (st_q == ST_WARM) ? CW'(WARM_CYC)
                    : (sel_q ? CW'(POR_LONG_CYC) : CW'(POR_SHORT_CYC));

    rstseq_timer #(.CW(CW)) u_tmr (
        .clk   (clk),
        .clr_n (cold_n),
        .hold  (tmr_hold),
        .lim   (tmr_lim),
        .done  (tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge cold_n) begin
        if (!cold_n) begin
            st_q <= ST_POR_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_POR_HOLD: begin
                if (sup_s) st_d = ST_POR_CNT;
            end
            ST_POR_CNT: begin
                if (!sup_s)        st_d = ST_POR_HOLD;
                else if (tmr_done) st_d = ST_RUN;
            end
            ST_WARM: begin
                if (!sup_s)        st_d = ST_POR_HOLD;
                else if (tmr_done) st_d = ST_RUN;
            end
            ST_RUN: begin
                if (!sup_s && !mdis_q) st_d = ST_POR_HOLD;
                else if (any_req)      st_d = mdis_q ? ST_POR_HOLD : ST_WARM;
            end
            default: st_d = ST_POR_HOLD;
        endcase
    end

    // cause priority: pin, then watchdog, then software
    always_comb begin
        cause = '0;
        if (pin_s)       cause[FLG_PIN]  = 1'b1;
        else if (wdog_s) cause[FLG_WDOG] = 1'b1;
        else             cause[FLG_SW]   = 1'b1;
    end

    assign set_por  = (st_q == ST_POR_CNT) && (st_d == ST_RUN);
    assign set_warm = (st_q == ST_RUN) && (st_d == ST_WARM);
    assign clr_mdis = (st_d == ST_POR_HOLD);
    assign mode_we  = (st_q == ST_RUN) && (st_d == ST_RUN) && mode_wr;

    rstseq_status u_stat (
        .clk      (clk),
        .clr_n    (cold_n),
        .set_por  (set_por),
        .set_warm (set_warm),
        .cause    (cause),
        .mode_we  (mode_we),
        .mode_din (mode_wdata[MODE_MDIS]),
        .clr_mdis (clr_mdis),
        .src_q    (src_q),
        .mdis_q   (mdis_q)
    );

    // outputs
    always_comb begin
        sys_rst             = (st_q != ST_RUN);
        rst_src             = src_q;
        mode_reg            = '0;
        mode_reg[MODE_MDIS] = mdis_q;
        start_addr          = BOOT_VEC;
    end
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk
    import rstseq_pkg::*;
(
    input logic      clk,
    input logic      cold_n,
    input logic      sup_s,
    input logic      mdis,
    input logic      any_req,
    input logic      mode_wr,
    input logic      sys_rst,
    input logic [7:0] rst_src,
    input logic [7:0] mode_reg,
    input rs_state_t st
);
    // R6
    supply_drop_chk: assert property (@(posedge clk) disable iff (!cold_n)
        (!sup_s && !mdis) |=> sys_rst);

    // R5
    warm_cause_chk: assert property (@(posedge clk) disable iff (!cold_n)
        (!sys_rst && any_req && sup_s && !mdis) |=>
            (sys_rst && !rst_src[1] && $countones(rst_src) == 1));

    // R8
    mdis_por_chk: assert property (@(posedge clk) disable iff (!cold_n)
        (!sys_rst && any_req && mdis) |=> (sys_rst && !mode_reg[5]));

    // R10
    mode_lock_chk: assert property (@(posedge clk) disable iff (!cold_n)
        (sys_rst && mode_wr) |=> $stable(mode_reg));

    // R3
    por_flag_chk: assert property (@(posedge clk) disable iff (!cold_n)
        ($fell(sys_rst) && $past(st == ST_POR_CNT)) |-> rst_src[1]);
endmodule

bind rstseq_top rstseq_chk u_chk (
    .clk      (clk),
    .cold_n   (cold_n),
    .sup_s    (sup_s),
    .mdis     (mdis_q),
    .any_req  (any_req),
    .mode_wr  (mode_wr),
    .sys_rst  (sys_rst),
    .rst_src  (rst_src),
    .mode_reg (mode_reg),
    .st       (st_q)
);

// File: tb/sim_rstseq_top.sv
`timescale 1ns/1ps
module sim_rstseq_top;
    localparam int SH = 40;
    localparam int LG = 90;
    localparam int WM = 16;

    logic       clk = 1'b0;
    logic       cold_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       dly_sel = 1'b0;
    logic       pin_req = 1'b0;
    logic       wdog_req = 1'b0;
    logic       sw_req = 1'b0;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_wdata = 8'h00;
    logic       sys_rst;
    logic [7:0] rst_src;
    logic [7:0] mode_reg;
    logic [15:0] start_addr;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #5 clk = ~clk;

    rstseq_top #(
        .POR_SHORT_CYC (SH),
        .POR_LONG_CYC  (LG),
        .WARM_CYC      (WM),
        .ADDR_W        (16),
        .BOOT_VEC      (16'h0000)
    ) u0 (
        .clk        (clk),
        .cold_n     (cold_n),
        .supply_ok  (supply_ok),
        .dly_sel    (dly_sel),
        .pin_req    (pin_req),
        .wdog_req   (wdog_req),
        .sw_req     (sw_req),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .sys_rst    (sys_rst),
        .rst_src    (rst_src),
        .mode_reg   (mode_reg),
        .start_addr (start_addr)
    );

    // behavioural reference model: 0 waiting, 1 power-on count, 2 warm, 3 running
    int   m_ph = 0;
    int   m_left = 0;
    bit   sy_a[2] = '{0, 0};
    bit   sy_p[2] = '{0, 0};
    bit   sy_w[2] = '{0, 0};
    logic [7:0] m_src = 8'h00;
    bit   m_dis = 1'b0;

    always @(posedge clk) begin
        if (!cold_n) begin
            m_ph = 0; m_left = 0; m_src = 8'h00; m_dis = 1'b0;
            sy_a = '{0, 0}; sy_p = '{0, 0}; sy_w = '{0, 0};
        end else begin
            case (m_ph)
                0: if (sy_a[1]) begin m_ph = 1; m_left = dly_sel ? LG : SH; end
                1: if (!sy_a[1]) m_ph = 0;
                   else begin
                       m_left--;
                       if (m_left == 0) begin m_ph = 3; m_src = 8'h02; end
                   end
                2: if (!sy_a[1]) m_ph = 0;
                   else begin
                       m_left--;
                       if (m_left == 0) m_ph = 3;
                   end
                default: begin
                    if (!sy_a[1] && !m_dis) m_ph = 0;
                    else if (sy_p[1] || sy_w[1] || sw_req) begin
                        if (m_dis) begin m_ph = 0; m_dis = 1'b0; end
                        else begin
                            m_ph = 2; m_left = WM;
                            m_src = sy_p[1] ? 8'h01 : (sy_w[1] ? 8'h04 : 8'h08);
                        end
                    end else if (mode_wr) m_dis = mode_wdata[5];
                end
            endcase
            sy_a[1] = sy_a[0]; sy_a[0] = supply_ok;
            sy_p[1] = sy_p[0]; sy_p[0] = pin_req;
            sy_w[1] = sy_w[0]; sy_w[0] = wdog_req;
        end
    end

    function automatic void chk(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endfunction

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk(sys_rst === (m_ph != 3), cur_req, "sys_rst", int'(sys_rst), int'(m_ph != 3));
            chk(mode_reg === {2'b00, m_dis, 5'b00000}, cur_req, "mode_reg",
                int'(mode_reg), int'({2'b00, m_dis, 5'b00000}));
            if (m_src[1])
                chk(rst_src[1] === 1'b1, cur_req, "power-on flag", int'(rst_src[1]), 1);
            else
                chk(rst_src === m_src, cur_req, "rst_src", int'(rst_src), int'(m_src));
            if (!sys_rst)
                chk(start_addr === 16'h0000, "R11", "start_addr", int'(start_addr), 0);
        end
    end

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    initial begin
        wait_n(3);
        cur_req = "R1";
        chk(sys_rst === 1'b1, "R1", "sys_rst in cold", int'(sys_rst), 1);
        cold_n = 1'b1;
        wait_n(1);
        chk(rst_src === 8'h00, "R1", "rst_src after cold", int'(rst_src), 0);
        chk(mode_reg === 8'h00, "R1", "mode_reg after cold", int'(mode_reg), 0);
        wait_n(4);

        cur_req = "R2";
        supply_ok = 1'b1;
        wait_n(SH + 2);
        chk(sys_rst === 1'b1, "R2", "sys_rst before short delay ends", int'(sys_rst), 1);
        wait_n(2);
        chk(sys_rst === 1'b0, "R2", "sys_rst after short delay", int'(sys_rst), 0);
        cur_req = "R3";
        chk(rst_src[1] === 1'b1, "R3", "power-on flag", int'(rst_src[1]), 1);
        wait_n(4);

        cur_req = "R4";
        pulse(pin_req);
        wait_n(WM + 6);
        cur_req = "R5";
        chk(rst_src === 8'h01, "R5", "pin cause", int'(rst_src), 1);
        pulse(wdog_req);
        wait_n(WM + 6);
        pulse(sw_req);
        wait_n(WM + 4);
        chk(rst_src === 8'h08, "R5", "software cause", int'(rst_src), 8);
        @(negedge clk); pin_req = 1'b1; wdog_req = 1'b1;
        @(negedge clk); pin_req = 1'b0; wdog_req = 1'b0;
        wait_n(WM + 6);

        cur_req = "R9";
        pulse(pin_req);
        wait_n(6);
        pulse(wdog_req);
        pulse(sw_req);
        wait_n(WM + 4);
        chk(rst_src === 8'h01, "R9", "cause after ignored requests", int'(rst_src), 1);

        cur_req = "R6";
        @(negedge clk); supply_ok = 1'b0; dly_sel = 1'b1;
        wait_n(5);
        supply_ok = 1'b1;
        wait_n(20);
        supply_ok = 1'b0;
        wait_n(3);
        supply_ok = 1'b1;
        wait_n(LG + 8);
        chk(sys_rst === 1'b0, "R6", "released after restart", int'(sys_rst), 0);

        cur_req = "R7";
        @(negedge clk); mode_wr = 1'b1; mode_wdata = 8'hFF;
        @(negedge clk); mode_wr = 1'b0;
        wait_n(2);
        supply_ok = 1'b0;
        wait_n(10);
        chk(sys_rst === 1'b0, "R7", "drop ignored when disabled", int'(sys_rst), 0);
        supply_ok = 1'b1;
        wait_n(4);

        cur_req = "R8";
        pulse(sw_req);
        wait_n(3);
        cur_req = "R10";
        mode_wr = 1'b1; mode_wdata = 8'h20;
        @(negedge clk); mode_wr = 1'b0;
        wait_n(2);
        chk(mode_reg === 8'h00, "R10", "write during reset", int'(mode_reg), 0);
        cur_req = "R8";
        wait_n(LG + 4);
        chk(sys_rst === 1'b0 && rst_src[1] === 1'b1, "R8", "full power-on after request",
            int'(rst_src[1]), 1);
        wait_n(4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule